// File: doc/BRIEF.md
# Lock-Aware Round-Robin Victim Way Selector

This block chooses which way of a set-associative cache receives a new line after a miss. One replacement pointer serves every set in the cache. The pointer holds only a way number. When a miss is presented, the block is given the lock bits and the replacement-enable bits of the addressed set. Starting at the pointer, it scans the ways in wrap-around order and reports, in the same cycle, the first way that is both enabled and unlocked.

If such a way exists, the block reports it as the victim and moves the pointer onto it, so that any skipping over locked ways persists. If every way of the set is locked or disabled, the block flags the access as a single-beat transfer with no line fill, and the pointer is left alone.

When the line fill finishes, the fill logic reports done together with an error flag. A clean completion moves the pointer one way further, wrapping modulo the way count. A failed completion leaves the pointer on the way it had chosen. A global invalidate has no effect on the pointer. Tag compare, data storage, the bus side and lock management all live outside this block.

Top module: `rr_victim_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, the pointer output reads way 0.
- R2: While miss_req is 1, victim_way is the first way whose replaceable condition holds. The scan starts at the current pointer and wraps, in the order ptr, ptr+1, … modulo NUM_WAYS. The result is valid in the same cycle, with no register in the path.
- R3: If miss_req is 1 and at least one way is replaceable, victim_valid is 1 and no_fill is 0. At the next clock edge the pointer takes the value of victim_way.
- R4: If miss_req is 1 and no way is replaceable, no_fill is 1 and victim_valid is 0. The pointer keeps its value.
- R5: fill_done=1 with fill_err=0 moves the pointer to (ptr+1) modulo NUM_WAYS at the next edge, so way NUM_WAYS-1 is followed by way 0.
- R6: fill_done=1 with fill_err=1 leaves the pointer unchanged. fill_err has no effect while fill_done is 0.
- R7: The flush input never changes the pointer.
- R8: While miss_req is 0, victim_valid and no_fill are both 0.
- R9: If miss_req and fill_done are both 1 in the same cycle, the miss commit takes priority. The pointer becomes victim_way and the fill completion is dropped.
- R10: Bit i of way_lock and bit i of way_en belong to way i. Way i is replaceable exactly when way_en[i]=1 and way_lock[i]=0, so a disabled way is skipped just like a locked one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| miss_req | input | 1 | A miss needs a victim this cycle |
| way_lock | input | NUM_WAYS | Lock bit per way of the addressed set |
| way_en | input | NUM_WAYS | Replacement-enable bit per way |
| fill_done | input | 1 | Line fill finished this cycle |
| fill_err | input | 1 | Finished fill ended with an error |
| flush | input | 1 | Global invalidate; does not touch the pointer |
| victim_way | output | WAY_W | Chosen way number |
| victim_valid | output | 1 | A replaceable way was found for this miss |
| no_fill | output | 1 | No way available: single-beat access, no fill |
| repl_ptr | output | WAY_W | Current replacement pointer |

## Verification
The bench sweeps all 256 combinations of lock and enable masks for four ways. Because the pointer carries over from one trial to the next, each mask meets several starting pointers. This separates a correct wrap-around scan from a fixed-priority scan, and it separates a locked way from a disabled one.

Fill outcomes alternate between clean and failed. This distinguishes advance-by-one from hold, and it exercises the 3-to-0 wrap. The all-blocked masks confirm the no-fill flag and the unchanged pointer.

Separate directed cases cover three things: a flush asserted alone, an error flag raised without done, and a miss that coincides with a fill completion. Each of these tells whether the pointer reacts to an input it must ignore, or which update wins.

// File: rtl/rr_victim_pkg.sv
package rr_victim_pkg;
  // cause of a pointer update in a given cycle
  typedef enum logic [1:0] {
    PU_HOLD    = 2'd0,
    PU_COMMIT  = 2'd1,
    PU_ADVANCE = 2'd2
  } ptr_upd_e;
endpackage

// File: rtl/victim_search.sv
module victim_search #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [WAY_W-1:0]    start_ptr,
  input  logic [NUM_WAYS-1:0] lock_mask,
  input  logic [NUM_WAYS-1:0] en_mask,
  output logic [NUM_WAYS-1:0] free_mask,
  output logic [WAY_W-1:0]    pick_way,
  output logic                pick_found
);
  // wrap-around add of an offset to a way number (power-of-two way count)
  function automatic logic [WAY_W-1:0] wrap_add(input logic [WAY_W-1:0] base,
                                                input int unsigned off);
    return WAY_W'(base + WAY_W'(off));
  endfunction

  assign free_mask = en_mask & ~lock_mask;  // R10

  logic [WAY_W-1:0]    cand [NUM_WAYS];
  logic [NUM_WAYS-1:0] cand_hit;

  for (genvar k = 0; k < NUM_WAYS; k++) begin : g_cand
    assign cand[k]     = wrap_add(start_ptr, k);
    assign cand_hit[k] = free_mask[cand[k]];
  end

  // lowest offset from the pointer wins (R2)
  always_comb begin
    pick_way   = start_ptr;
    pick_found = 1'b0;
    for (int k = NUM_WAYS - 1; k >= 0; k--) begin
      if (cand_hit[k]) begin
        pick_way   = cand[k];
        pick_found = 1'b1;
      end
    end
  end

  initial begin
    pow2_ways_chk: assert ((1 << WAY_W) == NUM_WAYS)
      else $error("NUM_WAYS must be a power of two");
  end
endmodule

// File: rtl/ptr_track.sv
module ptr_track
  import rr_victim_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  logic [WAY_W-1:0] commit_way,
  input  logic             fill_ok,
  input  logic             flush,
  output logic [WAY_W-1:0] ptr
);
  function automatic logic [WAY_W-1:0] next_way(input logic [WAY_W-1:0] w);
    return WAY_W'(w + 1'b1);
  endfunction

  ptr_upd_e         upd;
  logic [WAY_W-1:0] ptr_nxt;

  // a miss commit outranks a fill completion (R9)
  always_comb begin
    if (commit)       upd = PU_COMMIT;
    else if (fill_ok) upd = PU_ADVANCE;
    else              upd = PU_HOLD;
  end

  always_comb begin
    unique case (upd)
      PU_COMMIT:  ptr_nxt = commit_way;
      PU_ADVANCE: ptr_nxt = next_way(ptr);
      default:    ptr_nxt = ptr;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr <= '0;
    else        ptr <= ptr_nxt;
  end

  // R3
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ptr == $past(commit_way));
  // R5
  clean_fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_ok && !commit) |=> ptr == WAY_W'($past(ptr) + 1'b1));
  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !commit && !fill_ok) |=> $stable(ptr));
endmodule

// File: rtl/rr_victim_sel.sv
module rr_victim_sel #(
  parameter int unsigned NUM_WAYS = 4,
  localparam int unsigned WAY_W = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                miss_req,
  input  logic [NUM_WAYS-1:0] way_lock,
  input  logic [NUM_WAYS-1:0] way_en,
  input  logic                fill_done,
  input  logic                fill_err,
  input  logic                flush,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_valid,
  output logic                no_fill,
  output logic [WAY_W-1:0]    repl_ptr
);
  logic [NUM_WAYS-1:0] free_ways;
  logic [WAY_W-1:0]    found_way;
  logic                any_free;
  logic                miss_commit;
  logic                fill_clean;

  victim_search #(.NUM_WAYS(NUM_WAYS)) u_search (
    .start_ptr  (repl_ptr),
    .lock_mask  (way_lock),
    .en_mask    (way_en),
    .free_mask  (free_ways),
    .pick_way   (found_way),
    .pick_found (any_free)
  );

  assign miss_commit = miss_req & any_free;
  assign fill_clean  = fill_done & ~fill_err;

  ptr_track #(.NUM_WAYS(NUM_WAYS)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .commit     (miss_commit),
    .commit_way (found_way),
    .fill_ok    (fill_clean),
    .flush      (flush),
    .ptr        (repl_ptr)
  );

  assign victim_way   = found_way;
  assign victim_valid = miss_commit;
  assign no_fill      = miss_req & ~any_free;

  // R2
  victim_is_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> (way_en[victim_way] && !way_lock[victim_way]));
  // R4
  nofill_all_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    no_fill |-> ((way_en & ~way_lock) == '0));
  // R4
  nofill_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (no_fill && !(fill_done && !fill_err)) |=> $stable(repl_ptr));
  // R6
  err_fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_done && fill_err && !miss_req) |=> $stable(repl_ptr));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !miss_req |-> (!victim_valid && !no_fill));
  // R3
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_req |-> $onehot({victim_valid, no_fill}));
endmodule

// File: tb/tb_rr_victim_sel.sv
module tb_rr_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          miss_req, fill_done, fill_err, flush;
  logic [NW-1:0] way_lock, way_en;
  logic [1:0]    victim_way, repl_ptr;
  logic          victim_valid, no_fill;

  int checks = 0;
  int errors = 0;
  int model_ptr = 0;
  bit done_flag = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_victim_sel #(.NUM_WAYS(NW)) dut (
    .clk(clk), .rst_n(rst_n), .miss_req(miss_req), .way_lock(way_lock),
    .way_en(way_en), .fill_done(fill_done), .fill_err(fill_err), .flush(flush),
    .victim_way(victim_way), .victim_valid(victim_valid), .no_fill(no_fill),
    .repl_ptr(repl_ptr)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference scan: first enabled, unlocked way from p, wrapping
  function automatic int ref_pick(input int p, input logic [NW-1:0] lk,
                                  input logic [NW-1:0] en, output bit found);
    found = 1'b0;
    for (int k = 0; k < NW; k++) begin
      int w = (p + k) % NW;
      if (en[w] && !lk[w]) begin
        found = 1'b1;
        return w;
      end
    end
    return 0;
  endfunction

  // issue one miss; returns whether a way was found
  task automatic do_miss(input logic [NW-1:0] lk, input logic [NW-1:0] en,
                         output bit found);
    int exp_w;
    miss_req = 1'b1; way_lock = lk; way_en = en;
    #1;
    exp_w = ref_pick(model_ptr, lk, en, found);
    chk(victim_valid == found, "R3 victim_valid", victim_valid, found);
    chk(no_fill == !found, "R4 no_fill", no_fill, !found);
    if (found) begin
      if (en != '1) chk(victim_way == exp_w, "R10 victim_way", victim_way, exp_w);
      else          chk(victim_way == exp_w, "R2 victim_way", victim_way, exp_w);
      model_ptr = exp_w;
    end
    @(posedge clk);
    @(negedge clk);
    miss_req = 1'b0;
    #1;
    chk(repl_ptr == model_ptr, found ? "R3 ptr commit" : "R4 ptr hold",
        repl_ptr, model_ptr);
    chk(!victim_valid && !no_fill, "R8 idle outputs", {victim_valid, no_fill}, 0);
  endtask

  task automatic do_fill(input bit err);
    @(negedge clk);
    fill_done = 1'b1; fill_err = err;
    @(posedge clk);
    @(negedge clk);
    fill_done = 1'b0; fill_err = 1'b0;
    if (!err) model_ptr = (model_ptr + 1) % NW;
    #1;
    chk(repl_ptr == model_ptr, err ? "R6 err fill hold" : "R5 clean advance",
        repl_ptr, model_ptr);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done_flag) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit found;
    rst_n = 1'b0; miss_req = 1'b0; fill_done = 1'b0; fill_err = 1'b0;
    flush = 1'b0; way_lock = '0; way_en = '1;
    repeat (3) @(negedge clk);
    #1;
    chk(repl_ptr == 0, "R1 ptr in reset", repl_ptr, 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(repl_ptr == 0, "R1 ptr after reset", repl_ptr, 0);
    chk(!victim_valid && !no_fill, "R8 idle after reset", {victim_valid, no_fill}, 0);

    // wrap 3 -> 0 with clean fills and all ways free (R5)
    for (int i = 0; i < 5; i++) do_fill(1'b0);

    // full sweep of lock and enable masks
    for (int m = 0; m < 256; m++) begin
      logic [7:0] mv = 8'(m);
      do_miss(mv[3:0], mv[7:4], found);
      if (found) do_fill(mv[0] ^ mv[5] ^ mv[2]);
      else       do_fill(1'b1);
    end

    // flush alone (R7)
    @(negedge clk);
    flush = 1'b1;
    repeat (3) @(negedge clk);
    flush = 1'b0;
    #1;
    chk(repl_ptr == model_ptr, "R7 flush ignored", repl_ptr, model_ptr);

    // fill_err without fill_done (R6)
    fill_err = 1'b1;
    repeat (2) @(negedge clk);
    fill_err = 1'b0;
    #1;
    chk(repl_ptr == model_ptr, "R6 err without done", repl_ptr, model_ptr);

    // miss together with clean fill completion: commit wins (R9)
    @(negedge clk);
    miss_req = 1'b1; fill_done = 1'b1; fill_err = 1'b0;
    way_en = '1;
    way_lock = ~(NW'(1) << ((model_ptr + 2) % NW));
    model_ptr = (model_ptr + 2) % NW;
    @(posedge clk);
    @(negedge clk);
    miss_req = 1'b0; fill_done = 1'b0;
    #1;
    chk(repl_ptr == model_ptr, "R9 commit beats fill", repl_ptr, model_ptr);

    // all four ways locked, with flush high as well (R4)
    @(negedge clk);
    flush = 1'b1;
    do_miss('1, '1, found);
    flush = 1'b0;
    chk(found == 1'b0, "R4 all locked", found, 0);

    done_flag = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule